// File: doc/BRIEF.md
# Dual-Rail Serial Word Receiver

This block takes 32-bit words off a two-wire return-to-zero line. One wire carries ones and the other carries zeroes. Each bit is a pulse on one wire for the first half of a bit-time, followed by a return to the idle state where both wires are low. The block samples the line on a tick that runs at four times the bit rate. A word is delimited by a run of idle bit-times. The block finds a bit at each rising edge of line activity, packs the bits into a shift register, and hands a complete word to a holding register. A host reads that register one byte at a time.

While it receives, the block checks the framing. A word must have exactly 32 bits before the idle gap. Both wires must never be active at once. When parity is enabled, each word must carry odd parity. A word that arrives before the host has finished reading the previous one is flagged. Each fault sets a sticky bit in a status byte, and a single error output is high while any of those bits is set. Reading the status byte clears it.

In self-test mode the block ignores its external line and sample tick. It takes the local transmitter's two wires and tick instead. The block compares no labels, so a word with any content raises no error for that reason.

Top module: `dual_rail_rx`

## Requirements
- R1: After `rst`, `ready`, `first_char` and `err` are low, and the status byte read with `sel_status`=1 is 0x00.
- R2: A bit is taken on a sampling tick where exactly one wire is high and neither was high at the previous tick. Its value is 1 when the ones wire is the active one. The first bit received becomes bit 0 of the word. A word is accepted when, after exactly 32 bits, the line stays idle for 12 consecutive ticks (three null bit-times). `ready` then rises.
- R3: With `sel_status`=0, `host_q` shows the byte that is next to be read, starting at byte 0 (word bits 7:0) and ending at byte 3 (bits 31:24). Each `rd_stb` pulse moves on to the next byte. The read of byte 3 drops `ready`.
- R4: `first_char` is high exactly while `ready` is high and the next byte to be read is byte 0.
- R5: When `par_en`=1, an accepted word with an even number of ones sets status bit 3, the parity error. The word is still delivered. When `par_en`=0, parity is not checked.
- R6: If the idle gap arrives after 1 to 31 bits, status bit 5 (sequence error) is set and no word is delivered.
- R7: A 33rd bit before the gap sets status bit 5. The word is discarded up to the next gap.
- R8: Both wires high on a sampling tick sets status bit 5. The current word is discarded up to the next gap.
- R9: A word accepted while `ready` is still high sets status bit 4 (overwrite). The new word replaces the old one, and reading starts again at byte 0.
- R10: `err` is the OR of status bits 3, 4 and 5. Status bits 0 to 2 and 6 to 7 read as 0. An `rd_stb` with `sel_status`=1 clears the status after it is read. An error raised in the same cycle stays set.
- R11: With `self_test`=1, the block uses `tx_one`, `tx_zero` and `tx_tick` in place of `rx_one`, `rx_zero` and `rx_tick`.
- R12: The line is sampled only on cycles where the selected tick is high. Activity without a tick has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Master reset, active high, synchronous |
| rx_tick | input | 1 | External sampling tick, 4x bit rate |
| rx_one | input | 1 | External ones wire |
| rx_zero | input | 1 | External zeroes wire |
| tx_tick | input | 1 | Transmitter tick, used in self test |
| tx_one | input | 1 | Transmitter ones wire, used in self test |
| tx_zero | input | 1 | Transmitter zeroes wire, used in self test |
| self_test | input | 1 | Selects the transmitter loopback as the source |
| par_en | input | 1 | Enables the odd-parity check |
| sel_status | input | 1 | 1 selects the status byte on `host_q`, 0 selects a data byte |
| rd_stb | input | 1 | One-cycle read strobe |
| host_q | output | 8 | Data byte or status byte |
| ready | output | 1 | A received word is waiting to be read |
| first_char | output | 1 | The next data byte to be read is byte 0 |
| err | output | 1 | One or more status error bits are set |

## Verification
The bench drives the line with complete words and reads back each byte. A receiver that packs bits in the wrong order or takes a bit at the wrong edge would return wrong bytes. The bench also sends words of 10 and 33 bits and words with both wires high. A design that counted badly would deliver these words, or flag them twice, instead of setting only bit 5. It sends two words without a read in between; a design that missed the overwrite would leave bit 4 clear or keep the old data. It feeds activity without a tick, and an external line carrying both-wires-high noise during self test. A design that ignored the tick gate or the source mux would show a false word or a false error.

// File: rtl/dual_rail_rx_pkg.sv
package dual_rail_rx_pkg;
    // Status byte bit positions
    localparam int ST_PAR = 3;
    localparam int ST_OVW = 4;
    localparam int ST_SEQ = 5;
    localparam int ST_BITS = 3;  // internal sticky vector: {seq, ovw, par}
endpackage

// File: rtl/dual_rail_front.sv
module dual_rail_front #(
    parameter int NULL_BITS = 3,
    parameter int TICKS_PER_BIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic self_test,
    input  logic rx_tick,
    input  logic rx_one,
    input  logic rx_zero,
    input  logic tx_tick,
    input  logic tx_one,
    input  logic tx_zero,
    output logic bit_evt,
    output logic bit_val,
    output logic illegal_evt,
    output logic gap_evt
);
    localparam int GAP_TICKS = NULL_BITS * TICKS_PER_BIT;
    localparam int GW = $clog2(GAP_TICKS + 1);
    localparam logic [GW-1:0] GAP_FULL = GW'(GAP_TICKS);
    localparam logic [GW-1:0] GAP_LAST = GW'(GAP_TICKS - 1);

    typedef struct packed {
        logic          prev_act;
        logic [GW-1:0] idle;
    } front_t;

    front_t s_d, s_q;
    logic   tick, one, zero, act;

    always_comb begin
        tick = self_test ? tx_tick : rx_tick;
        one  = self_test ? tx_one  : rx_one;
        zero = self_test ? tx_zero : rx_zero;
        act  = one | zero;

        bit_evt     = tick && act && !s_q.prev_act && !(one && zero);
        bit_val     = one;
        illegal_evt = tick && one && zero;
        gap_evt     = tick && !act && (s_q.idle == GAP_LAST);

        s_d = s_q;
        if (tick) begin
            s_d.prev_act = act;
            if (act) begin
                s_d.idle = '0;
            end else if (s_q.idle != GAP_FULL) begin
                s_d.idle = s_q.idle + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.prev_act <= 1'b0;
            s_q.idle     <= GAP_FULL;
        end else begin
            s_q <= s_d;
        end
    end

    // R12
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(s_q));

    // R2
    gap_idle_chk: assert property (@(posedge clk) disable iff (rst)
        gap_evt |=> (s_q.idle == GAP_FULL) && !s_q.prev_act);
endmodule

// File: rtl/dual_rail_framer.sv
module dual_rail_framer #(
    parameter int WORD_BITS = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 par_en,
    input  logic                 bit_evt,
    input  logic                 bit_val,
    input  logic                 illegal_evt,
    input  logic                 gap_evt,
    output logic                 word_stb,
    output logic [WORD_BITS-1:0] word,
    output logic                 par_err,
    output logic                 seq_err
);
    localparam int CW = $clog2(WORD_BITS + 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(WORD_BITS);

    typedef struct packed {
        logic [WORD_BITS-1:0] shreg;
        logic [CW-1:0]        cnt;
        logic                 bad;
        logic [WORD_BITS-1:0] word;
        logic                 word_stb;
        logic                 par_err;
        logic                 seq_err;
    } frm_t;

    frm_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.word_stb = 1'b0;
        s_d.par_err  = 1'b0;
        s_d.seq_err  = 1'b0;

        if (illegal_evt) begin
            s_d.seq_err = 1'b1;
            s_d.bad     = 1'b1;
        end else if (bit_evt && !s_q.bad) begin
            if (s_q.cnt == CNT_FULL) begin
                s_d.seq_err = 1'b1;
                s_d.bad     = 1'b1;
            end else begin
                s_d.shreg = {bit_val, s_q.shreg[WORD_BITS-1:1]};
                s_d.cnt   = s_q.cnt + 1'b1;
            end
        end else if (gap_evt) begin
            if (!s_q.bad && s_q.cnt == CNT_FULL) begin
                s_d.word_stb = 1'b1;
                s_d.word     = s_q.shreg;
                s_d.par_err  = par_en && !(^s_q.shreg);
            end else if (!s_q.bad && s_q.cnt != '0) begin
                s_d.seq_err = 1'b1;
            end
            s_d.cnt = '0;
            s_d.bad = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign word_stb = s_q.word_stb;
    assign word     = s_q.word;
    assign par_err  = s_q.par_err;
    assign seq_err  = s_q.seq_err;

    // R2
    stb_after_gap_chk: assert property (@(posedge clk) disable iff (rst)
        s_q.word_stb |-> $past(gap_evt));

    // R8
    illegal_flag_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_evt |=> s_q.seq_err && !s_q.word_stb);

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        s_q.cnt <= CNT_FULL);
endmodule

// File: rtl/dual_rail_host_port.sv
module dual_rail_host_port
    import dual_rail_rx_pkg::*;
#(
    parameter int WORD_BITS = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 word_stb,
    input  logic [WORD_BITS-1:0] word,
    input  logic                 par_err,
    input  logic                 seq_err,
    input  logic                 sel_status,
    input  logic                 rd_stb,
    output logic [7:0]           host_q,
    output logic                 ready,
    output logic                 first_char,
    output logic                 err
);
    localparam int BYTES = WORD_BITS / 8;
    localparam int IW = (BYTES > 1) ? $clog2(BYTES) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(BYTES - 1);

    typedef struct packed {
        logic [WORD_BITS-1:0] word;
        logic                 ready;
        logic [IW-1:0]        idx;
        logic [ST_BITS-1:0]   status;  // {seq, ovw, par}
    } host_t;

    host_t              s_d, s_q;
    logic [ST_BITS-1:0] new_err;
    logic [7:0]         byte_sel;
    logic [7:0]         status_byte;

    always_comb begin
        new_err = {seq_err, word_stb && s_q.ready, par_err};

        s_d = s_q;
        if (word_stb) begin
            s_d.word  = word;
            s_d.ready = 1'b1;
            s_d.idx   = '0;
        end else if (rd_stb && !sel_status && s_q.ready) begin
            if (s_q.idx == LAST_IDX) begin
                s_d.ready = 1'b0;
                s_d.idx   = '0;
            end else begin
                s_d.idx = s_q.idx + 1'b1;
            end
        end

        if (rd_stb && sel_status) begin
            s_d.status = new_err;
        end else begin
            s_d.status = s_q.status | new_err;
        end
    end

    always_comb begin
        byte_sel = '0;
        for (int b = 0; b < BYTES; b++) begin
            if (s_q.idx == IW'(b)) begin
                byte_sel = s_q.word[b*8 +: 8];
            end
        end
        status_byte         = '0;
        status_byte[ST_PAR] = s_q.status[0];
        status_byte[ST_OVW] = s_q.status[1];
        status_byte[ST_SEQ] = s_q.status[2];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign host_q     = sel_status ? status_byte : byte_sel;
    assign ready      = s_q.ready;
    assign first_char = s_q.ready && (s_q.idx == '0);
    assign err        = |s_q.status;

    // R3
    ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(s_q.ready) |-> $past(rd_stb && !sel_status && s_q.idx == LAST_IDX));

    // R4
    first_needs_ready_chk: assert property (@(posedge clk) disable iff (rst)
        first_char |-> ready);

    // R9
    overwrite_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (word_stb && s_q.ready) |=> s_q.status[1] && s_q.idx == '0);

    // R10
    status_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && sel_status && !word_stb && !par_err && !seq_err) |=> !err);
endmodule

// File: rtl/dual_rail_rx.sv
module dual_rail_rx #(
    parameter int WORD_BITS = 32,
    parameter int NULL_BITS = 3,
    parameter int TICKS_PER_BIT = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_tick,
    input  logic       rx_one,
    input  logic       rx_zero,
    input  logic       tx_tick,
    input  logic       tx_one,
    input  logic       tx_zero,
    input  logic       self_test,
    input  logic       par_en,
    input  logic       sel_status,
    input  logic       rd_stb,
    output logic [7:0] host_q,
    output logic       ready,
    output logic       first_char,
    output logic       err
);
    logic                 bit_evt, bit_val, illegal_evt, gap_evt;
    logic                 word_stb, par_err, seq_err;
    logic [WORD_BITS-1:0] word;

    dual_rail_front #(
        .NULL_BITS    (NULL_BITS),
        .TICKS_PER_BIT(TICKS_PER_BIT)
    ) u_front (
        .clk        (clk),
        .rst        (rst),
        .self_test  (self_test),
        .rx_tick    (rx_tick),
        .rx_one     (rx_one),
        .rx_zero    (rx_zero),
        .tx_tick    (tx_tick),
        .tx_one     (tx_one),
        .tx_zero    (tx_zero),
        .bit_evt    (bit_evt),
        .bit_val    (bit_val),
        .illegal_evt(illegal_evt),
        .gap_evt    (gap_evt)
    );

    dual_rail_framer #(
        .WORD_BITS(WORD_BITS)
    ) u_framer (
        .clk        (clk),
        .rst        (rst),
        .par_en     (par_en),
        .bit_evt    (bit_evt),
        .bit_val    (bit_val),
        .illegal_evt(illegal_evt),
        .gap_evt    (gap_evt),
        .word_stb   (word_stb),
        .word       (word),
        .par_err    (par_err),
        .seq_err    (seq_err)
    );

    dual_rail_host_port #(
        .WORD_BITS(WORD_BITS)
    ) u_host (
        .clk       (clk),
        .rst       (rst),
        .word_stb  (word_stb),
        .word      (word),
        .par_err   (par_err),
        .seq_err   (seq_err),
        .sel_status(sel_status),
        .rd_stb    (rd_stb),
        .host_q    (host_q),
        .ready     (ready),
        .first_char(first_char),
        .err       (err)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> !ready && !err && !first_char);
endmodule

// File: tb/dual_rail_rx_bench.sv
`timescale 1ns/1ps
module dual_rail_rx_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_tick = 1'b1, rx_one = 1'b0, rx_zero = 1'b0;
    logic       tx_tick = 1'b0, tx_one = 1'b0, tx_zero = 1'b0;
    logic       self_test = 1'b0, par_en = 1'b0, sel_status = 1'b0, rd_stb = 1'b0;
    logic [7:0] host_q;
    logic       ready, first_char, err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    dual_rail_rx u_dual_rail_rx (
        .clk(clk), .rst(rst),
        .rx_tick(rx_tick), .rx_one(rx_one), .rx_zero(rx_zero),
        .tx_tick(tx_tick), .tx_one(tx_one), .tx_zero(tx_zero),
        .self_test(self_test), .par_en(par_en),
        .sel_status(sel_status), .rd_stb(rd_stb),
        .host_q(host_q), .ready(ready), .first_char(first_char), .err(err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // drive one wire pair on the source chosen by self_test
    task automatic drive(input logic one, input logic zero);
        if (self_test) begin tx_one = one; tx_zero = zero; end
        else           begin rx_one = one; rx_zero = zero; end
    endtask

    task automatic send_bit(input logic v);
        drive(v, !v); cyc(2);
        drive(1'b0, 1'b0); cyc(2);
    endtask

    task automatic send_gap();
        drive(1'b0, 1'b0); cyc(16);
    endtask

    task automatic send_bits(input logic [63:0] w, input int n);
        for (int i = 0; i < n; i++) send_bit(w[i]);
    endtask

    function automatic logic [31:0] odd_word(input logic [31:0] w);
        logic [31:0] r = w;
        if (^r == 1'b0) r[31] = ~r[31];
        return r;
    endfunction

    task automatic pulse_rd(input logic st);
        sel_status = st; rd_stb = 1'b1; cyc(1);
        rd_stb = 1'b0; sel_status = 1'b0;
    endtask

    task automatic read_status(input string req, input logic [7:0] exp);
        sel_status = 1'b1; #1;
        check(req, host_q, exp);
        pulse_rd(1'b1);
        #1 check(req, err, 1'b0);
    endtask

    task automatic read_word(input string req, input logic [31:0] exp);
        for (int b = 0; b < 4; b++) begin
            check(req, ready, 1'b1);
            check("R4 first_char", first_char, b == 0);
            check(req, host_q, exp[b*8 +: 8]);
            pulse_rd(1'b0);
        end
        #1 check("R3 ready drop", ready, 1'b0);
    endtask

    task automatic t_reset();
        check("R1 ready", ready, 0);
        check("R1 first_char", first_char, 0);
        check("R1 err", err, 0);
        sel_status = 1'b1; #1 check("R1 status", host_q, 8'h00); sel_status = 1'b0;
    endtask

    task automatic t_basic();
        logic [31:0] w = odd_word(32'h1234_5678);
        par_en = 1'b1;
        send_bits({32'b0, w}, 32); send_gap();
        check("R2 word ready", ready, 1);
        check("R5 no parity error", err, 0);
        read_word("R3 byte", w);
        par_en = 1'b0;
    endtask

    task automatic t_parity();
        logic [31:0] w = odd_word(32'hA5C3_0F01) ^ 32'h1;
        par_en = 1'b1;
        send_bits({32'b0, w}, 32); send_gap();
        check("R5 err high", err, 1);
        read_status("R5 parity bit3", 8'h08);
        read_word("R5 word kept", w);
        par_en = 1'b0;
        send_bits({32'b0, w}, 32); send_gap();
        check("R5 disabled", err, 0);
        read_word("R5 word", w);
    endtask

    task automatic t_short();
        send_bits(64'h3FF, 10); send_gap();
        check("R6 no word", ready, 0);
        check("R6 err", err, 1);
        read_status("R6 seq bit5", 8'h20);
    endtask

    task automatic t_long();
        send_bits(64'h1_FFFF_0000, 33); send_gap();
        check("R7 no word", ready, 0);
        read_status("R7 seq bit5", 8'h20);
    endtask

    task automatic t_illegal();
        send_bits(64'h5, 3);
        drive(1'b1, 1'b1); cyc(2); drive(1'b0, 1'b0); cyc(2);
        send_bits(64'hFFFF_FFFF, 29); send_gap();
        check("R8 no word", ready, 0);
        read_status("R8 seq bit5", 8'h20);
    endtask

    task automatic t_overwrite();
        send_bits(64'h1111_2222, 32); send_gap();
        send_bits(64'hCAFE_BEEF, 32); send_gap();
        check("R9 err", err, 1);
        read_word("R9 new word", 32'hCAFE_BEEF);
        read_status("R9 ovw bit4", 8'h10);
    endtask

    task automatic t_notick();
        rx_tick = 1'b0;
        send_bits(64'h8765_4321, 32); send_gap();
        check("R12 no word", ready, 0);
        check("R12 no err", err, 0);
        rx_tick = 1'b1; cyc(4);
    endtask

    task automatic t_selftest();
        rx_tick = 1'b0; rx_one = 1'b1; rx_zero = 1'b1;  // noisy outside line
        self_test = 1'b1; tx_tick = 1'b1; cyc(2);
        send_bits(64'h0BAD_F00D, 32); send_gap();
        check("R11 loop err", err, 0);
        read_word("R11 loop word", 32'h0BAD_F00D);
        self_test = 1'b0; tx_tick = 1'b0; rx_one = 1'b0; rx_zero = 1'b0; rx_tick = 1'b1;
        send_gap();
        check("R11 back err", err, 0);
    endtask

    initial begin
        cyc(3); rst = 1'b0; cyc(1);
        t_reset();
        t_basic();
        t_parity();
        t_short();
        t_long();
        t_illegal();
        t_overwrite();
        t_notick();
        t_selftest();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule